// File: doc/BRIEF.md
# Paging mode control unit

This block keeps the control bits that govern address translation and works out which translation mode they select. Three small control registers feed it, each with its own write strobe. A system-control register holds the paging enable. An extension register holds the physical-address-extension enable, the large-page enable and the process-context-identifier enable. An extended-features register holds the long-mode enable, the no-execute enable and a read-only long-mode-active status bit. From the accepted register state, the block drives the mode code, the linear-address width, a mask of legal page sizes and three feature-active flags. Every output is registered.

Software can never set the status bit directly. The block recomputes it from paging enable and long-mode enable, and it drops the matching bit of any value written to the extended-features register. The block also refuses every register update that would leave long mode enabled while paging is on and the extension is off. A refused update leaves all three registers as they were and raises a one-cycle error pulse. There is no data stream in this block. All pins are plain control and status levels, with no valid/ready handshake and no back-pressure.

Top module: `pgmode_ctl`

## Requirements
- R1: After reset, `mode` is 00, `lin_width` is 32, `page_sizes` is 0, `feat_rdata` is 0, and `xd_on`, `pcid_on`, `pkey_on` and `wr_err` are all 0.
- R2: While the paging enable is 0, `mode` is 00 and `page_sizes` is 0, whatever the extension and long-mode bits hold.
- R3: With paging on, `mode` is 01 when the extension bit is 0. It is 10 when the extension bit is 1 and long mode is 0, and it is 11 when both are 1.
- R4: Bit 10 of `feat_rdata` always equals paging enable AND long-mode enable. Bit 0 of `feat_rdata` reads back long-mode enable, bit 1 reads back no-execute enable, and every other bit reads 0.
- R5: A write to the extended-features register takes long-mode enable from `feat_wdata` bit 0 and no-execute enable from bit 1. It ignores bit 10 and all other bits.
- R6: If the strobes of one cycle would together produce paging=1, extension=0 and long mode=1, none of that cycle's writes is applied. In that case `wr_err` is 1 for exactly the following cycle, and it is 0 otherwise.
- R7: `lin_width` is 48 in mode 11 and 32 in every other mode.
- R8: `page_sizes` uses bit 0 for 4 KB, bit 1 for 4 MB, bit 2 for 2 MB and bit 3 for 1 GB. Bit 0 is set in every paging mode. Bit 1 is set only in mode 01 with the large-page enable at 1. Bit 2 is set in modes 10 and 11. Bit 3 is set only in mode 11 while `cap_1g` is 1.
- R9: `xd_on` is 1 only in mode 10 or 11 while the no-execute enable is 1.
- R10: `pcid_on` is 1 only in mode 11 with the identifier enable at 1. `pkey_on` is 1 exactly in mode 11.
- R11: An accepted write, or a change on `cap_1g`, appears on the outputs at the first rising edge after the cycle in which it was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_we | input | 1 | System-control register write strobe |
| sys_pg | input | 1 | Paging enable value to write |
| ext_we | input | 1 | Extension register write strobe |
| ext_pae | input | 1 | Physical-address-extension enable value |
| ext_pse | input | 1 | Large-page (4 MB) enable value |
| ext_pcid | input | 1 | Process-context-identifier enable value |
| feat_we | input | 1 | Extended-features register write strobe |
| feat_wdata | input | 12 | Extended-features write value (bit 0 long mode, bit 1 no-execute, bit 10 ignored) |
| cap_1g | input | 1 | Capability: 1 GB pages supported |
| mode | output | 2 | Active mode: 00 none, 01 32-bit, 10 extended, 11 long |
| lin_width | output | 6 | Linear-address width in bits |
| page_sizes | output | 4 | Legal page sizes mask |
| xd_on | output | 1 | Execute-disable enforcement active |
| pcid_on | output | 1 | Context identifiers active |
| pkey_on | output | 1 | Protection keys available |
| feat_rdata | output | 12 | Extended-features readback including status bit 10 |
| wr_err | output | 1 | One-cycle pulse for a refused write |

## Verification
Every register bit is visible at the ports. A wrong paging, extension or long-mode bit changes `mode`, and a wrong long-mode or no-execute bit changes `feat_rdata`. The status bit can be cross-checked against the mode code, because a set bit 10 must come with mode 11. A wrongly accepted illegal write shows up one edge later as an unchanged `wr_err` together with a changed mode. A stale or early decode shows up at the first edge after the strobe, because nothing in the block takes more than one register stage.

// File: rtl/pgmode_pkg.sv
package pgmode_pkg;
  localparam int FEAT_W     = 12;
  localparam int LME_BIT    = 0;
  localparam int NXE_BIT    = 1;
  localparam int LMA_BIT    = 10;
  localparam int LW_W       = 6;
  localparam int LIN_LEGACY = 32;
  localparam int LIN_LONG   = 48;
  localparam int NSIZES     = 4;
  localparam int SZ_4K      = 0;
  localparam int SZ_4M      = 1;
  localparam int SZ_2M      = 2;
  localparam int SZ_1G      = 3;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_32   = 2'b01,
    MODE_PAE  = 2'b10,
    MODE_LONG = 2'b11
  } mode_e;

  typedef struct packed {
    logic pg;
    logic pae;
    logic pse;
    logic pcid;
    logic lme;
    logic nxe;
  } ctl_t;
endpackage

// File: rtl/pgmode_regs.sv
module pgmode_regs
  import pgmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_we,
  input  logic              sys_pg,
  input  logic              ext_we,
  input  logic              ext_pae,
  input  logic              ext_pse,
  input  logic              ext_pcid,
  input  logic              feat_we,
  input  logic [FEAT_W-1:0] feat_wdata,
  output ctl_t              nxt,
  output logic              reject
);
  ctl_t cur;
  ctl_t cand;
  logic unused_wbits;

  // Only two value bits are taken; the status position and the rest are dropped.
  assign unused_wbits = ^feat_wdata;

  always_comb begin
    cand = cur;
    if (sys_we) cand.pg = sys_pg;
    if (ext_we) begin
      cand.pae  = ext_pae;
      cand.pse  = ext_pse;
      cand.pcid = ext_pcid;
    end
    if (feat_we) begin
      cand.lme = feat_wdata[LME_BIT];
      cand.nxe = feat_wdata[NXE_BIT];
    end
  end

  // Long mode may not be enabled under non-extended paging.
  assign reject = cand.pg & ~cand.pae & cand.lme;
  assign nxt    = reject ? cur : cand;

  always_ff @(posedge clk) begin
    if (!rst_n) cur <= '0;
    else        cur <= nxt;
  end
endmodule

// File: rtl/pgmode_decode.sv
module pgmode_decode
  import pgmode_pkg::*;
(
  input  ctl_t              c,
  input  logic              cap_1g,
  output mode_e             mode,
  output logic [LW_W-1:0]   lin_w,
  output logic [NSIZES-1:0] sizes,
  output logic              xd,
  output logic              pcid,
  output logic              pkey,
  output logic [FEAT_W-1:0] feat
);
  always_comb begin
    if (!c.pg)      mode = MODE_NONE;
    else if (!c.pae) mode = MODE_32;
    else if (!c.lme) mode = MODE_PAE;
    else            mode = MODE_LONG;
  end

  assign lin_w = (mode == MODE_LONG) ? LW_W'(LIN_LONG) : LW_W'(LIN_LEGACY);

  always_comb begin
    sizes = '0;
    unique case (mode)
      MODE_NONE: sizes = '0;
      MODE_32: begin
        sizes[SZ_4K] = 1'b1;
        sizes[SZ_4M] = c.pse;
      end
      MODE_PAE: begin
        sizes[SZ_4K] = 1'b1;
        sizes[SZ_2M] = 1'b1;
      end
      MODE_LONG: begin
        sizes[SZ_4K] = 1'b1;
        sizes[SZ_2M] = 1'b1;
        sizes[SZ_1G] = cap_1g;
      end
    endcase
  end

  assign xd   = mode[1] & c.nxe;
  assign pcid = (mode == MODE_LONG) & c.pcid;
  assign pkey = (mode == MODE_LONG);

  always_comb begin
    feat          = '0;
    feat[LME_BIT] = c.lme;
    feat[NXE_BIT] = c.nxe;
    feat[LMA_BIT] = c.pg & c.lme;
  end
endmodule

// File: rtl/pgmode_ctl.sv
module pgmode_ctl
  import pgmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sys_we,
  input  logic              sys_pg,
  input  logic              ext_we,
  input  logic              ext_pae,
  input  logic              ext_pse,
  input  logic              ext_pcid,
  input  logic              feat_we,
  input  logic [FEAT_W-1:0] feat_wdata,
  input  logic              cap_1g,
  output logic [1:0]        mode,
  output logic [LW_W-1:0]   lin_width,
  output logic [NSIZES-1:0] page_sizes,
  output logic              xd_on,
  output logic              pcid_on,
  output logic              pkey_on,
  output logic [FEAT_W-1:0] feat_rdata,
  output logic              wr_err
);
  ctl_t              nxt;
  logic              reject;
  mode_e             d_mode;
  logic [LW_W-1:0]   d_lin;
  logic [NSIZES-1:0] d_sizes;
  logic              d_xd, d_pcid, d_pkey;
  logic [FEAT_W-1:0] d_feat;

  pgmode_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .sys_we(sys_we), .sys_pg(sys_pg),
    .ext_we(ext_we), .ext_pae(ext_pae), .ext_pse(ext_pse), .ext_pcid(ext_pcid),
    .feat_we(feat_we), .feat_wdata(feat_wdata),
    .nxt(nxt), .reject(reject)
  );

  // Decode the state the registers take at this edge, so outputs track it with no extra lag.
  pgmode_decode u_dec (
    .c(nxt), .cap_1g(cap_1g),
    .mode(d_mode), .lin_w(d_lin), .sizes(d_sizes),
    .xd(d_xd), .pcid(d_pcid), .pkey(d_pkey), .feat(d_feat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode       <= MODE_NONE;
      lin_width  <= LW_W'(LIN_LEGACY);
      page_sizes <= '0;
      xd_on      <= 1'b0;
      pcid_on    <= 1'b0;
      pkey_on    <= 1'b0;
      feat_rdata <= '0;
      wr_err     <= 1'b0;
    end else begin
      mode       <= d_mode;
      lin_width  <= d_lin;
      page_sizes <= d_sizes;
      xd_on      <= d_xd;
      pcid_on    <= d_pcid;
      pkey_on    <= d_pkey;
      feat_rdata <= d_feat;
      wr_err     <= reject;
    end
  end
endmodule

// File: rtl/pgmode_chk.sv
module pgmode_chk
  import pgmode_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic [LW_W-1:0]   lin_width,
  input logic [NSIZES-1:0] page_sizes,
  input logic              xd_on,
  input logic              pcid_on,
  input logic              pkey_on,
  input logic [FEAT_W-1:0] feat_rdata,
  input logic              wr_err
);
  // R4
  status_matches_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feat_rdata[LMA_BIT] == (mode == 2'b11));

  // R6
  refused_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> ($stable(mode) && $stable(feat_rdata)));

  // R7
  width_follows_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_width == LW_W'(LIN_LONG)) == (mode == 2'b11));

  // R8
  large_page_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page_sizes[SZ_4M] |-> mode == 2'b01) and (page_sizes[SZ_1G] |-> mode == 2'b11));

  // R2
  no_paging_no_sizes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (page_sizes == '0));

  // R9
  xd_needs_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xd_on |-> mode[1]);

  // R10
  pcid_needs_keys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pcid_on |-> pkey_on) and (pkey_on == (mode == 2'b11)));
endmodule

bind pgmode_ctl pgmode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .lin_width(lin_width),
  .page_sizes(page_sizes), .xd_on(xd_on), .pcid_on(pcid_on),
  .pkey_on(pkey_on), .feat_rdata(feat_rdata), .wr_err(wr_err)
);

// File: tb/pgmode_ctl_tb.sv
`timescale 1ns/1ps
module pgmode_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sys_we = 0, sys_pg = 0;
  logic        ext_we = 0, ext_pae = 0, ext_pse = 0, ext_pcid = 0;
  logic        feat_we = 0;
  logic [11:0] feat_wdata = '0;
  logic        cap_1g = 0;
  logic [1:0]  mode;
  logic [5:0]  lin_width;
  logic [3:0]  page_sizes;
  logic        xd_on, pcid_on, pkey_on, wr_err;
  logic [11:0] feat_rdata;

  always #4 clk = ~clk;

  pgmode_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .sys_we(sys_we), .sys_pg(sys_pg),
    .ext_we(ext_we), .ext_pae(ext_pae), .ext_pse(ext_pse), .ext_pcid(ext_pcid),
    .feat_we(feat_we), .feat_wdata(feat_wdata), .cap_1g(cap_1g),
    .mode(mode), .lin_width(lin_width), .page_sizes(page_sizes),
    .xd_on(xd_on), .pcid_on(pcid_on), .pkey_on(pkey_on),
    .feat_rdata(feat_rdata), .wr_err(wr_err)
  );

  typedef struct {
    logic [1:0]  mode;
    logic [5:0]  lw;
    logic [3:0]  sz;
    logic        xd, pcid, pkey, err;
    logic [11:0] feat;
    string       req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  logic m_pg = 0, m_pae = 0, m_pse = 0, m_pcid = 0, m_lme = 0, m_nxe = 0;

  function automatic exp_t model(logic pg, logic pae, logic pse, logic pc,
                                 logic lme, logic nxe, logic cap, logic err, string req);
    exp_t e;
    e.mode = !pg ? 2'b00 : !pae ? 2'b01 : !lme ? 2'b10 : 2'b11;
    e.lw   = (e.mode == 2'b11) ? 6'd48 : 6'd32;
    e.sz   = 4'b0000;
    if (e.mode == 2'b01) e.sz = {2'b00, pse, 1'b1};
    if (e.mode == 2'b10) e.sz = 4'b0101;
    if (e.mode == 2'b11) e.sz = {cap, 3'b101};
    e.xd   = e.mode[1] & nxe;
    e.pcid = (e.mode == 2'b11) & pc;
    e.pkey = (e.mode == 2'b11);
    e.feat = '0;
    e.feat[0]  = lme;
    e.feat[1]  = nxe;
    e.feat[10] = pg & lme;
    e.err  = err;
    e.req  = req;
    return e;
  endfunction

  task automatic step(input logic sw, input logic spg, input logic ew, input logic epae,
                      input logic epse, input logic epc, input logic fw, input logic [11:0] fd,
                      input logic cap, input string req);
    logic n_pg, n_pae, n_pse, n_pc, n_lme, n_nxe, bad;
    @(negedge clk);
    sys_we = sw; sys_pg = spg; ext_we = ew; ext_pae = epae; ext_pse = epse;
    ext_pcid = epc; feat_we = fw; feat_wdata = fd; cap_1g = cap;
    n_pg  = sw ? spg : m_pg;
    n_pae = ew ? epae : m_pae;
    n_pse = ew ? epse : m_pse;
    n_pc  = ew ? epc : m_pcid;
    n_lme = fw ? fd[0] : m_lme;
    n_nxe = fw ? fd[1] : m_nxe;
    bad   = n_pg & ~n_pae & n_lme;
    if (!bad) begin
      m_pg = n_pg; m_pae = n_pae; m_pse = n_pse; m_pcid = n_pc; m_lme = n_lme; m_nxe = n_nxe;
    end
    q.push_back(model(m_pg, m_pae, m_pse, m_pcid, m_lme, m_nxe, cap, bad, req));
  endtask

  task automatic compare(exp_t e);
    n_chk++;
    if (mode !== e.mode || lin_width !== e.lw || page_sizes !== e.sz || xd_on !== e.xd ||
        pcid_on !== e.pcid || pkey_on !== e.pkey || feat_rdata !== e.feat || wr_err !== e.err) begin
      n_bad++;
      $display("FAIL %s: got mode=%b lw=%0d sz=%b xd=%b pcid=%b pkey=%b feat=%h err=%b exp mode=%b lw=%0d sz=%b xd=%b pcid=%b pkey=%b feat=%h err=%b",
               e.req, mode, lin_width, page_sizes, xd_on, pcid_on, pkey_on, feat_rdata, wr_err,
               e.mode, e.lw, e.sz, e.xd, e.pcid, e.pkey, e.feat, e.err);
    end
  endtask

  // Monitor: just after each edge, the oldest expected item must match.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) compare(q.pop_front());
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, sampled before any edge with reset released
    compare(model(0, 0, 0, 0, 0, 0, 0, 0, "R1"));
    step(0,0, 0,0,0,0, 1,12'h001, 0, "R2");   // long mode bit set, paging off
    step(1,1, 0,0,0,0, 0,12'h000, 0, "R6");   // paging on with ext off: refused
    step(0,0, 1,1,0,0, 0,12'h000, 0, "R2");   // ext on, still no paging
    step(1,1, 0,0,0,0, 0,12'h000, 0, "R3");   // long mode, status bit R4
    step(0,0, 0,0,0,0, 1,12'h003, 0, "R5");   // bit 10 written 0, status stays; R9 xd
    step(0,0, 1,1,0,1, 0,12'h000, 1, "R10");  // pcid on, 1 GB cap R8
    step(0,0, 0,0,0,0, 0,12'h000, 0, "R11");  // cap drop visible next edge
    step(0,0, 1,0,0,1, 0,12'h000, 0, "R6");   // ext off under long mode: refused
    step(0,0, 0,0,0,0, 1,12'h400, 0, "R5");   // bit 10 written 1, long mode off -> R3 ext mode, R7
    step(0,0, 0,0,0,0, 1,12'h002, 0, "R9");   // xd in ext mode, pcid off R10
    step(0,0, 1,0,1,1, 0,12'h000, 0, "R8");   // 32-bit mode with 4 MB
    step(0,0, 1,0,0,1, 0,12'h000, 0, "R8");   // 4 MB gone
    step(0,0, 0,0,0,0, 1,12'h001, 0, "R6");   // long mode in 32-bit mode: refused
    step(1,0, 0,0,0,0, 1,12'h001, 0, "R2");   // same cycle paging off + long mode: legal
    step(1,1, 0,0,0,0, 0,12'h000, 0, "R6");   // paging on again: refused
    step(0,0, 0,0,0,0, 0,12'hFFC, 0, "R11");  // no strobe: ignored data, error pulse ends
    step(0,0, 1,1,1,0, 0,12'h000, 0, "R3");   // ext on, paging still off
    step(1,1, 0,0,0,0, 0,12'h000, 1, "R4");   // long mode again, status bit set
    step(0,0, 0,0,0,0, 0,12'h000, 1, "R7");
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule